// File: doc/BRIEF.md
# Modbus RTU Master Link Supervisor

This block supervises the master end of a half-duplex Modbus RTU link. A request start from the host opens a transaction. The block then waits for the framer to report a received frame with a good CRC. If the CRC is bad, or if no frame arrives within a response window, the attempt has failed. After a failed attempt the block waits a backoff period and then asks for the request to be sent again. Once a fixed retry budget is spent, the transaction is abandoned and reported as failed.

The response window and the backoff are both counted in half-character ticks supplied from the baud logic, so they scale with the baud rate. Each backoff is at least the 3.5-character bus silence. On top of that it adds a pseudo-random number of whole characters, so that masters sharing a bus do not retry in lockstep.

Alongside the transaction logic, the block keeps a set of error logs. There is a saturating counter and a last-event timestamp for each of four error classes: CRC, response timeout, UART framing and UART overrun. A separate saturating counter is kept for each reset-cause code, together with the most recent code. This lets power events be told apart from link faults.

Top module: `mb_link_supervisor`

## Requirements
- R1: After reset, `retransmit`, `txn_done`, `txn_fail` and `busy` are low, and every counter is zero.
- R2: While idle, `req_start` opens a transaction and raises `busy`. A `frame_done` with `crc_ok` high during the wait gives exactly one one-cycle `txn_done` pulse, and `busy` falls with it. At most one of `retransmit`, `txn_done` and `txn_fail` is high in any cycle.
- R3: If no frame arrives within 2*TMO_CHARS half-character ticks, counted after the start or after the latest retransmit, the attempt fails and the timeout counter (class slice 1) increments.
- R4: After a failed attempt that still has retries left, `retransmit` pulses on the (7 + 2*E)-th half tick that follows. E is bits [1:0] of a 16-bit LFSR. The LFSR is seeded with 0xACE1. It shifts left once per backoff, and bit 0 takes the XOR of bits 15, 13, 12 and 10. E is read before the shift.
- R5: A `frame_done` with `crc_ok` low during the wait increments the CRC counter (class slice 0) and fails the attempt in the same way as a timeout.
- R6: No retransmit is issued earlier than 7 half ticks (3.5 characters) after the failed attempt.
- R7: After MAX_RETRY retransmits, the next failed attempt gives a one-cycle `txn_fail` pulse instead of a retransmit, and `busy` falls.
- R8: `req_start` has no effect while a transaction is in progress: the response timer is not restarted and the sequence of outcomes is unchanged.
- R9: `uart_frm_err` and `uart_ovr_err` increment the framing counter (slice 2) and the overrun counter (slice 3). They do not affect the transaction.
- R10: Every counter saturates at all-ones.
- R11: A free-running counter is cleared by reset and advances by one each clock. Each error class stores that counter's value from the cycle in which its event is seen, in slice `k` of `err_ts`.
- R12: A cycle with `rst_cause_vld` high copies `rst_cause` into `last_cause` and increments that code's counter in `cause_cnt`.
- R13: `cnt_clear` zeroes all error and cause counters on the next cycle, and takes priority over events in the same cycle. Timestamps are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Host request to open a transaction |
| frame_done | input | 1 | Framer reports a complete received frame |
| crc_ok | input | 1 | CRC of that frame matched (valid with `frame_done`) |
| uart_frm_err | input | 1 | UART framing error pulse |
| uart_ovr_err | input | 1 | UART overrun error pulse |
| half_tick | input | 1 | One-cycle pulse per half character time |
| rst_cause_vld | input | 1 | Reset-cause code is valid this cycle |
| rst_cause | input | CAUSE_W | Reset-cause code |
| cnt_clear | input | 1 | Synchronous clear of all counters |
| retransmit | output | 1 | One-cycle request to send the request again |
| txn_done | output | 1 | One-cycle pulse: transaction succeeded |
| txn_fail | output | 1 | One-cycle pulse: transaction abandoned |
| busy | output | 1 | Transaction in progress |
| err_cnt | output | 4*CNT_W | Error counters; slice 0 CRC, 1 timeout, 2 framing, 3 overrun |
| err_ts | output | 4*TS_W | Last-event timestamps in the same slice order |
| cause_cnt | output | NUM_CAUSE*CNT_W | Counter per reset-cause code |
| last_cause | output | CAUSE_W | Most recent reset-cause code |

## Verification
The assertions assume the following about the inputs: `half_tick` and `frame_done` are single-cycle pulses, `crc_ok` is only meaningful when `frame_done` is high, and `rst_cause` stays below NUM_CAUSE. The stimulus drives every input on the falling clock edge. It produces one half tick every four clocks, and it presents frames only while a response is awaited. Outcome pulses are matched against a queue of expected events. Each event carries the half-tick count at which it should appear, and that count is worked out from the timeout length and an independent LFSR model.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int NUM_CLS    = 4;
  localparam int CLS_CRC    = 0;
  localparam int CLS_TMO    = 1;
  localparam int CLS_FRM    = 2;
  localparam int CLS_OVR    = 3;
  localparam int SILENCE_HT = 7;   // 3.5 characters in half-character ticks

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BACK} txn_st_e;

  // Shift left; feedback taps for x^16 + x^14 + x^13 + x^11 + 1
  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Backoff length: mandatory silence plus 0..3 whole characters
  function automatic logic [3:0] backoff_ht(input logic [1:0] extra);
    return 4'(SILENCE_HT) + {1'b0, extra, 1'b0};
  endfunction
endpackage

// File: rtl/mbs_lfsr.sv
module mbs_lfsr
  import mbs_pkg::*;
#(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  output logic [1:0] extra
);
  logic [15:0] state;

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= lfsr_next(state);
  end

  assign extra = state[1:0];
endmodule

// File: rtl/mbs_txn_fsm.sv
module mbs_txn_fsm
  import mbs_pkg::*;
#(
  parameter int MAX_RETRY = 3,
  parameter int TMO_CHARS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_start,
  input  logic       frame_done,
  input  logic       crc_ok,
  input  logic       half_tick,
  input  logic [1:0] rnd,
  output logic       lfsr_step,
  output logic       crc_ev,
  output logic       tmo_ev,
  output logic       retransmit,
  output logic       txn_done,
  output logic       txn_fail,
  output logic       busy
);
  localparam int TMO_TICKS = 2 * TMO_CHARS;
  localparam int TMO_W     = $clog2(TMO_TICKS + 1);
  localparam int RETRY_W   = $clog2(MAX_RETRY + 1);

  txn_st_e              st;
  logic [RETRY_W-1:0]   attempts;
  logic [TMO_W-1:0]     tmo_cnt;
  logic [3:0]           bo_cnt;
  logic [3:0]           sil_cnt;   // half ticks since the failed attempt

  logic in_wait, good_rx, att_fail, give_up, retry_load, retx_fire;

  assign in_wait    = (st == ST_WAIT);
  assign good_rx    = in_wait & frame_done & crc_ok;
  assign crc_ev     = in_wait & frame_done & ~crc_ok;
  assign tmo_ev     = in_wait & ~frame_done & half_tick &
                      (tmo_cnt == TMO_W'(TMO_TICKS - 1));
  assign att_fail   = crc_ev | tmo_ev;
  assign give_up    = att_fail & (attempts == RETRY_W'(MAX_RETRY));
  assign retry_load = att_fail & ~give_up;
  assign retx_fire  = (st == ST_BACK) & half_tick & (bo_cnt == 4'd1);
  assign lfsr_step  = retry_load;
  assign busy       = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      attempts   <= '0;
      tmo_cnt    <= '0;
      bo_cnt     <= '0;
      sil_cnt    <= '0;
      retransmit <= 1'b0;
      txn_done   <= 1'b0;
      txn_fail   <= 1'b0;
    end else begin
      retransmit <= retx_fire;
      txn_done   <= good_rx;
      txn_fail   <= give_up;
      case (st)
        ST_IDLE: if (req_start) begin
          st       <= ST_WAIT;
          attempts <= '0;
          tmo_cnt  <= '0;
        end
        ST_WAIT: begin
          if (good_rx || give_up) st <= ST_IDLE;
          else if (retry_load) begin
            st       <= ST_BACK;
            attempts <= attempts + 1'b1;
            bo_cnt   <= backoff_ht(rnd);
            sil_cnt  <= '0;
          end else if (half_tick) tmo_cnt <= tmo_cnt + 1'b1;
        end
        ST_BACK: if (half_tick) begin
          if (bo_cnt == 4'd1) begin
            st      <= ST_WAIT;
            tmo_cnt <= '0;
          end else bo_cnt <= bo_cnt - 4'd1;
          if (sil_cnt != 4'hF) sil_cnt <= sil_cnt + 4'd1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retransmit, txn_done, txn_fail}));

  p_silence_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retx_fire |-> (sil_cnt >= 4'(SILENCE_HT - 1)));

  p_retry_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retransmit |-> (attempts != '0) && (attempts <= RETRY_W'(MAX_RETRY)));

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && req_start && !frame_done && !half_tick) |=> (in_wait && $stable(tmo_cnt)));
endmodule

// File: rtl/mbs_err_log.sv
module mbs_err_log #(
  parameter int N     = 4,
  parameter int CNT_W = 8,
  parameter int TS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [N-1:0]      ev,
  input  logic [TS_W-1:0]   now,
  output logic [N*CNT_W-1:0] cnt_flat,
  output logic [N*TS_W-1:0]  ts_flat
);
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_cls
    logic [CNT_W-1:0] c;
    logic [TS_W-1:0]  t;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c <= '0;
        t <= '0;
      end else begin
        if (clr)        c <= '0;
        else if (ev[g]) c <= sat_inc(c);
        if (ev[g])      t <= now;
      end
    end

    assign cnt_flat[g*CNT_W +: CNT_W] = c;
    assign ts_flat[g*TS_W +: TS_W]    = t;

    p_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((c == '1) && !clr) |=> (c == '1));
    p_ts_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ev[g] |=> (t == $past(now)));
    p_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (c == '0));
  end
endmodule

// File: rtl/mbs_cause_log.sv
module mbs_cause_log #(
  parameter int NUM_CAUSE = 4,
  parameter int CNT_W     = 8,
  localparam int CW       = $clog2(NUM_CAUSE)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      vld,
  input  logic [CW-1:0]             code,
  output logic [CW-1:0]             last_code,
  output logic [NUM_CAUSE*CNT_W-1:0] cnt_flat
);
  always_ff @(posedge clk) begin
    if (!rst_n)   last_code <= '0;
    else if (vld) last_code <= code;
  end

  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_cause
    logic [CNT_W-1:0] c;
    logic hit;
    assign hit = vld && (code == CW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)              c <= '0;
      else if (clr)            c <= '0;
      else if (hit && !(&c))   c <= c + 1'b1;
    end

    assign cnt_flat[g*CNT_W +: CNT_W] = c;

    p_cause_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !clr && !(&c)) |=> (c == $past(c) + 1'b1));
  end

  p_cause_latch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> (last_code == $past(code)));
endmodule

// File: rtl/mb_link_supervisor.sv
module mb_link_supervisor
  import mbs_pkg::*;
#(
  parameter int          CNT_W     = 8,
  parameter int          TS_W      = 32,
  parameter int          MAX_RETRY = 3,
  parameter int          TMO_CHARS = 8,
  parameter int          NUM_CAUSE = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int         CAUSE_W   = $clog2(NUM_CAUSE)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_start,
  input  logic                       frame_done,
  input  logic                       crc_ok,
  input  logic                       uart_frm_err,
  input  logic                       uart_ovr_err,
  input  logic                       half_tick,
  input  logic                       rst_cause_vld,
  input  logic [CAUSE_W-1:0]         rst_cause,
  input  logic                       cnt_clear,
  output logic                       retransmit,
  output logic                       txn_done,
  output logic                       txn_fail,
  output logic                       busy,
  output logic [NUM_CLS*CNT_W-1:0]   err_cnt,
  output logic [NUM_CLS*TS_W-1:0]    err_ts,
  output logic [NUM_CAUSE*CNT_W-1:0] cause_cnt,
  output logic [CAUSE_W-1:0]         last_cause
);
  logic [TS_W-1:0]    tstamp;
  logic [1:0]         rnd;
  logic               lfsr_step, crc_ev, tmo_ev;
  logic [NUM_CLS-1:0] ev;

  always_ff @(posedge clk) begin
    if (!rst_n) tstamp <= '0;
    else        tstamp <= tstamp + 1'b1;
  end

  always_comb begin
    ev          = '0;
    ev[CLS_CRC] = crc_ev;
    ev[CLS_TMO] = tmo_ev;
    ev[CLS_FRM] = uart_frm_err;
    ev[CLS_OVR] = uart_ovr_err;
  end

  mbs_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(lfsr_step), .extra(rnd)
  );

  mbs_txn_fsm #(.MAX_RETRY(MAX_RETRY), .TMO_CHARS(TMO_CHARS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .frame_done(frame_done),
    .crc_ok(crc_ok), .half_tick(half_tick), .rnd(rnd), .lfsr_step(lfsr_step),
    .crc_ev(crc_ev), .tmo_ev(tmo_ev), .retransmit(retransmit),
    .txn_done(txn_done), .txn_fail(txn_fail), .busy(busy)
  );

  mbs_err_log #(.N(NUM_CLS), .CNT_W(CNT_W), .TS_W(TS_W)) u_err (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clear), .ev(ev), .now(tstamp),
    .cnt_flat(err_cnt), .ts_flat(err_ts)
  );

  mbs_cause_log #(.NUM_CAUSE(NUM_CAUSE), .CNT_W(CNT_W)) u_cause (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clear), .vld(rst_cause_vld),
    .code(rst_cause), .last_code(last_cause), .cnt_flat(cause_cnt)
  );
endmodule

// File: tb/tb_mb_link_supervisor.sv
module tb_mb_link_supervisor;
  localparam int MAXR = 3;
  localparam int TMO  = 16;   // 2 * TMO_CHARS half ticks
  localparam int CW   = 8;
  localparam int TW   = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_start = 0, frame_done = 0, crc_ok = 0, uart_frm_err = 0, uart_ovr_err = 0;
  logic half_tick = 0, rst_cause_vld = 0, cnt_clear = 0;
  logic [1:0] rst_cause = '0;
  logic retransmit, txn_done, txn_fail, busy;
  logic [4*CW-1:0] err_cnt;
  logic [4*TW-1:0] err_ts;
  logic [4*CW-1:0] cause_cnt;
  logic [1:0] last_cause;

  mb_link_supervisor dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .frame_done(frame_done),
    .crc_ok(crc_ok), .uart_frm_err(uart_frm_err), .uart_ovr_err(uart_ovr_err),
    .half_tick(half_tick), .rst_cause_vld(rst_cause_vld), .rst_cause(rst_cause),
    .cnt_clear(cnt_clear), .retransmit(retransmit), .txn_done(txn_done),
    .txn_fail(txn_fail), .busy(busy), .err_cnt(err_cnt), .err_ts(err_ts),
    .cause_cnt(cause_cnt), .last_cause(last_cause)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int htc = 0, tcyc = 0, ph = 0;
  int qk[$], qt[$];
  logic [15:0] bl = 16'hACE1;
  int exp_cnt[4] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin htc <= 0; tcyc <= 0; end
    else begin tcyc <= tcyc + 1; if (half_tick) htc <= htc + 1; end
  end

  always @(negedge clk) begin
    ph <= (ph + 1) % 4;
    half_tick <= (ph == 3);
  end

  function automatic logic [15:0] bnext(input logic [15:0] s);
    logic fb = ^(s & 16'hB400);
    return {s[14:0], fb};
  endfunction

  task automatic chk(input string req, input string what, input longint got, input longint expv);
    n_chk++;
    if (got != expv) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
    end
  endtask

  task automatic push(input int k, input int t);
    qk.push_back(k); qt.push_back(t);
  endtask

  task automatic drain();
    wait (qk.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_counts(input string req);
    for (int i = 0; i < 4; i++)
      chk(req, $sformatf("err_cnt[%0d]", i), err_cnt[i*CW +: CW], exp_cnt[i]);
  endtask

  // Scoreboard monitor: kind 1 retransmit, 2 done, 3 fail
  always @(negedge clk) begin
    if (rst_n && (retransmit || txn_done || txn_fail)) begin
      int kind, k, t;
      string tag;
      kind = retransmit ? 1 : (txn_done ? 2 : 3);
      tag  = (kind == 1) ? "R4/R6 retransmit" : ((kind == 2) ? "R2 done" : "R7 fail");
      n_chk++;
      if (qk.size() == 0) begin
        n_fail++;
        $display("FAIL %s unexpected: got kind %0d at tick %0d expected none", tag, kind, htc);
      end else begin
        k = qk.pop_front(); t = qt.pop_front();
        if (k != kind || (t >= 0 && t != htc)) begin
          n_fail++;
          $display("FAIL %s: got kind %0d tick %0d expected kind %0d tick %0d", tag, kind, htc, k, t);
        end
      end
    end
  end

  // Silent slave: R3 timeouts, R4/R6 backoff, R7 give-up, optional R8 poke
  task automatic silent_txn(input bit poke);
    int t;
    @(negedge clk) req_start = 1;
    @(negedge clk) req_start = 0;
    t = htc;
    for (int a = 0; a <= MAXR; a++) begin
      t += TMO;
      if (a < MAXR) begin
        t += 7 + 2 * int'(bl[1:0]);
        bl = bnext(bl);
        push(1, t);
      end else push(3, t);
    end
    if (poke) begin
      repeat (20) @(negedge clk);
      req_start = 1;
      @(negedge clk) req_start = 0;
    end
    drain();
    exp_cnt[1] += MAXR + 1;
    chk("R7", "busy after fail", busy, 0);
  endtask

  int ts_ovr, ts_crc, ts_frm;

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "outputs", {retransmit, txn_done, txn_fail, busy}, 0);
    chk("R1", "err_cnt", err_cnt, 0);
    chk("R1", "cause_cnt", cause_cnt, 0);

    // Good reply with an overrun flag mid-transaction (R2, R9, R11)
    @(negedge clk) req_start = 1;
    @(negedge clk) req_start = 0;
    chk("R2", "busy raised", busy, 1);
    repeat (4) @(negedge clk);
    uart_ovr_err = 1; ts_ovr = tcyc;
    @(negedge clk) uart_ovr_err = 0;
    repeat (8) @(negedge clk);
    push(2, -1);
    frame_done = 1; crc_ok = 1;
    @(negedge clk) begin frame_done = 0; crc_ok = 0; end
    drain();
    exp_cnt[3] += 1;
    chk("R2", "busy after done", busy, 0);
    check_counts("R9");
    chk("R11", "overrun timestamp", err_ts[3*TW +: TW], ts_ovr);

    // No reply, with a second req_start while waiting (R3, R4, R7, R8)
    silent_txn(1'b1);
    check_counts("R3");

    // Bad CRC, retry, then good reply (R5, R4, R11)
    begin
      int t;
      @(negedge clk) req_start = 1;
      @(negedge clk) req_start = 0;
      repeat (8) @(negedge clk);
      frame_done = 1; crc_ok = 0; ts_crc = tcyc;
      @(negedge clk) frame_done = 0;
      t = htc + 7 + 2 * int'(bl[1:0]);
      bl = bnext(bl);
      push(1, t);
      wait (qk.size() == 0);
      repeat (10) @(negedge clk);
      push(2, -1);
      frame_done = 1; crc_ok = 1;
      @(negedge clk) begin frame_done = 0; crc_ok = 0; end
      drain();
      exp_cnt[0] += 1;
      check_counts("R5");
      chk("R11", "crc timestamp", err_ts[0 +: TW], ts_crc);
    end

    // Second silent transaction: later LFSR values (R4, R3)
    silent_txn(1'b0);
    check_counts("R3");

    // Reset-cause logging (R12)
    @(negedge clk) begin rst_cause_vld = 1; rst_cause = 2; end
    @(negedge clk) rst_cause = 2;
    @(negedge clk) rst_cause = 1;
    @(negedge clk) rst_cause_vld = 0;
    @(negedge clk);
    chk("R12", "cause 2 count", cause_cnt[2*CW +: CW], 2);
    chk("R12", "cause 1 count", cause_cnt[1*CW +: CW], 1);
    chk("R12", "last cause", last_cause, 1);

    // Saturation of the framing counter (R10, R11)
    @(negedge clk) uart_frm_err = 1;
    repeat (259) @(negedge clk);
    ts_frm = tcyc;
    @(negedge clk) uart_frm_err = 0;
    @(negedge clk);
    chk("R10", "framing saturated", err_cnt[2*CW +: CW], 255);
    chk("R11", "framing timestamp", err_ts[2*TW +: TW], ts_frm);
    chk("R9", "idle after flags", busy, 0);

    // Clear wins over a same-cycle event; timestamps kept (R13)
    @(negedge clk) begin cnt_clear = 1; uart_ovr_err = 1; end
    @(negedge clk) begin cnt_clear = 0; uart_ovr_err = 0; end
    chk("R13", "err_cnt cleared", err_cnt, 0);
    chk("R13", "cause_cnt cleared", cause_cnt, 0);
    chk("R13", "framing timestamp kept", err_ts[2*TW +: TW], ts_frm);

    repeat (5) @(negedge clk);
    chk("R2", "pending scoreboard items", qk.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule